// File: doc/BRIEF.md
# Handshake Backpressure Stall Injector

The stall injector sits between a producer and a consumer on a valid/acknowledge stream. A test uses it to make the consumer side look slow on purpose: for each data item the producer offers, the injector holds off acceptance for a programmed number of cycles, then lets the item through. The stall lengths come from a small on-chip list. The list is written through a programming port while the injector is held in reset. Each offered item uses up one list entry, in address order. Once the list is used up, the stream passes straight through.

A configuration bit selects stall mode or plain pass-through. A two-bit selector picks what the injector drives on the upstream acknowledge while no data is offered: constant low, constant high, or an undefined value. An optional warm-up count keeps acknowledge low for a set number of cycles after reset is released. During any stall, the forward valid toward the consumer is masked. This prevents a duplicate transfer. The upstream acknowledge stays low even if the consumer is ready, so the producer keeps its data.

Top module: `stall_injector`

## Requirements
- R1: While rst_ni is low, up_ack_o and dn_valid_o are both 0.
- R2: With cfg_stall_en_i = 0, dn_valid_o equals up_valid_i, dn_data_o equals up_data_i and up_ack_o equals dn_ack_i in every cycle.
- R3: With cfg_stall_en_i = 1, up_ack_o and dn_valid_o stay 0 for the first init_cycles_i cycles after reset release. Any per-item countdown starts only after that window.
- R4: In stall mode, an item whose list entry holds k is masked (dn_valid_o = 0) for the first k cycles it is offered. It is presented downstream in cycle k, counting the first offer cycle as cycle 0.
- R5: Successive offered items use list entries 0, 1, 2, and so on in address order. The next entry is taken only after the current item is transferred (dn_valid_o and dn_ack_i both 1).
- R6: While an offered item is masked, up_ack_o is 0 regardless of dn_ack_i.
- R7: In stall mode with up_valid_i = 0 after the warm-up window, up_ack_o is 0 when idle_ack_sel_i = 0 and 1 when idle_ack_sel_i = 1. Code 2 drives an undefined value and code 3 behaves like code 0.
- R8: After list_len_i items have been transferred, the stream behaves as pass-through with no further stalls.
- R9: An entry of 0 forwards its item in its first offered cycle.
- R10: Once an item is presented downstream, dn_valid_o stays 1 until dn_ack_i accepts it. up_ack_o equals dn_ack_i in those cycles.
- R11: prog_we_i writes prog_data_i into entry prog_addr_i only while rst_ni is low. A write with rst_ni high leaves the list unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cfg_stall_en_i | input | 1 | 1 selects stall mode, 0 selects pass-through |
| idle_ack_sel_i | input | 2 | Acknowledge level driven while no data is offered |
| init_cycles_i | input | INIT_W | Warm-up cycles with acknowledge held low after reset |
| list_len_i | input | IDX_W+1 | Number of valid list entries (clamped to DEPTH) |
| prog_we_i | input | 1 | List write enable (only acts during reset) |
| prog_addr_i | input | IDX_W | List write address |
| prog_data_i | input | ENT_W | Stall length to write |
| up_valid_i | input | 1 | Producer offers data |
| up_data_i | input | DATA_W | Producer data |
| up_ack_o | output | 1 | Acknowledge to producer |
| dn_valid_o | output | 1 | Valid toward consumer |
| dn_data_o | output | DATA_W | Data toward consumer |
| dn_ack_i | input | 1 | Consumer accepts |

## Verification
Every output is combinational from the current inputs and from registers updated at the previous edge, so each result is due in the same cycle as its stimulus. The bench drives inputs on the falling edge and samples one nanosecond later, before the next rising edge. For a stalled item, it counts the cycles from the first offer to the first cycle with dn_valid_o high, and compares that count with the list entry. It adds the warm-up length, minus the one cycle that passes between reset release and the first offer. A scoreboard queue checks the data and order of every transfer at the consumer side.

// File: rtl/stall_inj_pkg.sv
package stall_inj_pkg;
  typedef enum logic [1:0] {
    IDLE_NACK  = 2'd0,
    IDLE_ACK   = 2'd1,
    IDLE_UNDEF = 2'd2,
    IDLE_RSVD  = 2'd3
  } idle_ack_e;
endpackage

// File: rtl/stall_list_mem.sv
module stall_list_mem #(
  parameter int DEPTH = 16,
  parameter int ENT_W = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_addr_i,
  input  logic [ENT_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0] rd_addr_i,
  output logic [ENT_W-1:0] rd_data_o
);
  logic [ENT_W-1:0] ent_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i) begin
      if (wr_en_i && wr_addr_i == IDX_W'(g)) ent_q[g] <= wr_data_i;
    end
  end

  assign rd_data_o = ent_q[rd_addr_i];
endmodule

// File: rtl/init_stall_timer.sv
module init_stall_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] cycles_i,
  output logic             busy_o
);
  logic [CNT_W-1:0] cnt_q;

  assign busy_o = en_i && (cnt_q < cycles_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (busy_o) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/item_stall_ctrl.sv
module item_stall_ctrl #(
  parameter int DEPTH = 16,
  parameter int ENT_W = 8,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             active_i,
  input  logic             offer_i,
  input  logic             take_i,
  input  logic [IDX_W:0]   list_len_i,
  input  logic [ENT_W-1:0] entry_i,
  output logic [IDX_W-1:0] rd_idx_o,
  output logic             block_o
);
  logic [IDX_W:0]   idx_q;
  logic             armed_q;
  logic [ENT_W-1:0] cnt_q;
  logic             engaged;

  assign engaged  = active_i && offer_i && (idx_q < list_len_i);
  assign block_o  = engaged && (armed_q ? (cnt_q != '0) : (entry_i != '0));
  assign rd_idx_o = idx_q[IDX_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q   <= '0;
      armed_q <= 1'b0;
      cnt_q   <= '0;
    end else if (take_i) begin
      armed_q <= 1'b0;
      if (engaged) idx_q <= idx_q + 1'b1;
    end else if (engaged) begin
      if (!armed_q) begin
        armed_q <= 1'b1;
        cnt_q   <= (entry_i == '0) ? '0 : entry_i - 1'b1;
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/stall_injector.sv
module stall_injector
  import stall_inj_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  parameter int ENT_W  = 8,
  parameter int INIT_W = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_stall_en_i,
  input  logic [1:0]        idle_ack_sel_i,
  input  logic [INIT_W-1:0] init_cycles_i,
  input  logic [IDX_W:0]    list_len_i,
  input  logic              prog_we_i,
  input  logic [IDX_W-1:0]  prog_addr_i,
  input  logic [ENT_W-1:0]  prog_data_i,
  input  logic              up_valid_i,
  input  logic [DATA_W-1:0] up_data_i,
  output logic              up_ack_o,
  output logic              dn_valid_o,
  output logic [DATA_W-1:0] dn_data_o,
  input  logic              dn_ack_i
);
  localparam logic [IDX_W:0] MAX_LEN = (IDX_W+1)'(DEPTH);

  logic             init_busy, item_block, gate, take;
  logic [IDX_W-1:0] rd_idx;
  logic [ENT_W-1:0] entry;
  logic [IDX_W:0]   eff_len;
  idle_ack_e        idle_sel;

  assign eff_len  = (list_len_i > MAX_LEN) ? MAX_LEN : list_len_i;
  assign idle_sel = idle_ack_e'(idle_ack_sel_i);

  stall_list_mem #(.DEPTH(DEPTH), .ENT_W(ENT_W)) u_mem (
    .clk_i    (clk_i),
    .wr_en_i  (prog_we_i && !rst_ni),
    .wr_addr_i(prog_addr_i),
    .wr_data_i(prog_data_i),
    .rd_addr_i(rd_idx),
    .rd_data_o(entry)
  );

  init_stall_timer #(.CNT_W(INIT_W)) u_init (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (cfg_stall_en_i),
    .cycles_i(init_cycles_i),
    .busy_o  (init_busy)
  );

  item_stall_ctrl #(.DEPTH(DEPTH), .ENT_W(ENT_W)) u_item (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .active_i  (cfg_stall_en_i && !init_busy),
    .offer_i   (up_valid_i),
    .take_i    (take),
    .list_len_i(eff_len),
    .entry_i   (entry),
    .rd_idx_o  (rd_idx),
    .block_o   (item_block)
  );

  assign gate       = cfg_stall_en_i && (init_busy || item_block);
  assign dn_valid_o = rst_ni && up_valid_i && !gate;
  assign dn_data_o  = up_data_i;
  assign take       = dn_valid_o && dn_ack_i;

  always_comb begin
    if (!rst_ni)              up_ack_o = 1'b0;
    else if (!cfg_stall_en_i) up_ack_o = dn_ack_i;
    else if (init_busy)       up_ack_o = 1'b0;
    else if (up_valid_i)      up_ack_o = take;
    else begin
      unique case (idle_sel)
        IDLE_ACK:   up_ack_o = 1'b1;
        IDLE_UNDEF: up_ack_o = 1'bx;
        default:    up_ack_o = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/stall_injector_chk.sv
module stall_injector_chk #(
  parameter int INIT_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_stall_en_i,
  input logic [1:0]        idle_ack_sel_i,
  input logic [INIT_W-1:0] init_cycles_i,
  input logic              up_valid_i,
  input logic              up_ack_o,
  input logic              dn_valid_o,
  input logic              dn_ack_i
);
  logic [INIT_W-1:0] since_q;
  logic              warm;

  assign warm = cfg_stall_en_i && (since_q < init_cycles_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   since_q <= '0;
    else if (warm) since_q <= since_q + 1'b1;
  end

  always @(posedge clk_i) begin
    if (!rst_ni) assert_reset_quiet_R1: assert (!up_ack_o && !dn_valid_o);
  end

  assert_bypass_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_stall_en_i |-> (dn_valid_o == up_valid_i && up_ack_o == dn_ack_i));

  assert_warmup_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    warm |-> (!up_ack_o && !dn_valid_o));

  assert_no_drop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_valid_i && up_ack_o) |-> (dn_valid_o && dn_ack_i));

  assert_idle_nack_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_stall_en_i && !warm && !up_valid_i && idle_ack_sel_i == 2'd0) |-> !up_ack_o);

  assert_idle_ack_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_stall_en_i && !warm && !up_valid_i && idle_ack_sel_i == 2'd1) |-> up_ack_o);

  assert_hold_fwd_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dn_valid_o && !dn_ack_i) |=> (dn_valid_o || !up_valid_i));
endmodule

bind stall_injector stall_injector_chk #(.INIT_W(INIT_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cfg_stall_en_i(cfg_stall_en_i),
  .idle_ack_sel_i(idle_ack_sel_i),
  .init_cycles_i (init_cycles_i),
  .up_valid_i    (up_valid_i),
  .up_ack_o      (up_ack_o),
  .dn_valid_o    (dn_valid_o),
  .dn_ack_i      (dn_ack_i)
);

// File: tb/tb_stall_injector.sv
`timescale 1ns/1ps
module tb_stall_injector;
  localparam int DATA_W = 8, DEPTH = 16, ENT_W = 8, INIT_W = 16;
  localparam int IDX_W = $clog2(DEPTH);

  logic clk = 0, rst_n = 0;
  logic cfg_stall = 0;
  logic [1:0] idle_sel = 0;
  logic [INIT_W-1:0] init_cyc = 0;
  logic [IDX_W:0] list_len = 0;
  logic prog_we = 0;
  logic [IDX_W-1:0] prog_addr = 0;
  logic [ENT_W-1:0] prog_data = 0;
  logic up_valid = 0;
  logic [DATA_W-1:0] up_data = 0;
  logic up_ack, dn_valid, dn_ack = 1;
  logic [DATA_W-1:0] dn_data;

  int checks = 0, errors = 0;
  int vals[16];
  logic [DATA_W-1:0] expq[$];
  bit finished = 0;

  always #2.5 clk = ~clk;

  stall_injector #(.DATA_W(DATA_W), .DEPTH(DEPTH), .ENT_W(ENT_W), .INIT_W(INIT_W)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cfg_stall_en_i(cfg_stall), .idle_ack_sel_i(idle_sel),
    .init_cycles_i(init_cyc), .list_len_i(list_len), .prog_we_i(prog_we),
    .prog_addr_i(prog_addr), .prog_data_i(prog_data), .up_valid_i(up_valid),
    .up_data_i(up_data), .up_ack_o(up_ack), .dn_valid_o(dn_valid), .dn_data_o(dn_data),
    .dn_ack_i(dn_ack)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input bit st, input logic [1:0] idl, input int init, input int len,
                          input int n);
    @(negedge clk);
    rst_n = 0; up_valid = 0; dn_ack = 1;
    cfg_stall = st; idle_sel = idl; init_cyc = INIT_W'(init); list_len = (IDX_W+1)'(len);
    for (int i = 0; i < n; i++) begin
      prog_we = 1; prog_addr = IDX_W'(i); prog_data = ENT_W'(vals[i]);
      @(negedge clk);
    end
    prog_we = 0;
    @(negedge clk);
    rst_n = 1;
  endtask

  // offer one item; returns cycle of first forward and total cycles until accepted
  task automatic send_item(input logic [DATA_W-1:0] d, input int exp_first, input int hold,
                           input string req, output int total);
    int cyc = 0, first = -1;
    bit acked = 0;
    expq.push_back(d);
    @(negedge clk);
    up_valid = 1; up_data = d;
    while (!acked && cyc < 2000) begin
      dn_ack = (cyc >= hold);
      #1;
      if (dn_valid && first < 0) first = cyc;
      if (!dn_valid && up_ack) check(0, "R6 ack while masked", 1, 0);
      if (dn_valid && !dn_ack && up_ack) check(0, "R10 ack without dn_ack", 1, 0);
      acked = up_ack;
      @(negedge clk);
      cyc++;
    end
    up_valid = 0; dn_ack = 1;
    total = cyc;
    check(first == exp_first, req, first, exp_first);
  endtask

  task automatic idle_check(input bit dn, input bit exp, input string req);
    @(negedge clk);
    up_valid = 0; dn_ack = dn;
    #1;
    check(up_ack == exp, req, int'(up_ack), int'(exp));
    dn_ack = 1;
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rst_n && dn_valid && dn_ack) begin
        if (expq.size() == 0) check(0, "R5 unexpected transfer", int'(dn_data), -1);
        else begin
          logic [DATA_W-1:0] e;
          e = expq.pop_front();
          check(dn_data == e, "R5 data order", int'(dn_data), int'(e));
        end
      end
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      check(0, "watchdog", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int t;
    // R1: reset keeps outputs quiet
    cfg_stall = 1;
    @(negedge clk);
    up_valid = 1; dn_ack = 1;
    #1;
    check(!up_ack, "R1 up_ack in reset", int'(up_ack), 0);
    check(!dn_valid, "R1 dn_valid in reset", int'(dn_valid), 0);
    up_valid = 0;

    // R2: bypass mode
    do_reset(0, 2'd0, 7, 0, 0);
    send_item(8'h11, 0, 0, "R2 bypass item a", t);
    send_item(8'h12, 0, 0, "R2 bypass item b", t);
    idle_check(1, 1, "R2 idle follows dn_ack high");
    idle_check(0, 0, "R2 idle follows dn_ack low");

    // R4/R5/R6/R7/R8: list 4,5,6
    vals[0] = 4; vals[1] = 5; vals[2] = 6;
    do_reset(1, 2'd0, 0, 3, 3);
    idle_check(1, 0, "R7 idle nack");
    send_item(8'h21, 4, 0, "R4 first entry 4", t);
    send_item(8'h22, 5, 0, "R5 second entry 5", t);
    send_item(8'h23, 6, 0, "R5 third entry 6", t);
    send_item(8'h24, 0, 0, "R8 list used up", t);
    idle_check(1, 0, "R7 idle nack after list");

    // R7 ack level, R9 zero entry, R10 downstream hold
    vals[0] = 0; vals[1] = 2;
    do_reset(1, 2'd1, 0, 2, 2);
    idle_check(0, 1, "R7 idle ack");
    send_item(8'h31, 0, 0, "R9 zero entry", t);
    send_item(8'h32, 2, 4, "R10 forward after stall", t);
    check(t == 5, "R10 held until dn_ack", t, 5);

    // R3: warm-up of 5 cycles
    vals[0] = 0;
    do_reset(1, 2'd0, 5, 1, 1);
    send_item(8'h41, 4, 0, "R3 warm-up delay", t);

    // R11: write outside reset is ignored
    vals[0] = 3;
    do_reset(1, 2'd0, 0, 1, 1);
    @(negedge clk);
    prog_we = 1; prog_addr = 0; prog_data = 8'd9;
    @(negedge clk);
    prog_we = 0;
    do_reset(1, 2'd0, 0, 1, 0);
    send_item(8'h51, 3, 0, "R11 entry unchanged", t);

    repeat (3) @(negedge clk);
    check(expq.size() == 0, "R5 all items delivered", expq.size(), 0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule